// File: doc/BRIEF.md
# Memory Window Address Translator

This block maps host memory addresses onto a card's memory space through a set of independently programmed windows for one socket. Each window holds a first page, a last page and a page offset, all at 4 KiB granularity. When the page of the host address falls inside an enabled window, the offset is added to that page modulo 2^14 pages. The sum is joined to the untouched low twelve host address bits, giving a 26-bit card address.

The matching window also tells the access logic whether to target attribute or common memory, whether the data path is 16 bits wide, and which timing set to use. Software programs the windows through byte-wide indexed register writes. The translation is purely combinational from the host address and the stored window state.

Top module: `mwt_translator`

## Requirements
- R1: After reset every window is disabled, and `hit`, `card_addr`, `attr_sel`, `wide16` and `tmr1_sel` are all zero.
- R2: Window n is programmed at indices 0x10+8n+k. k=0 sets first-page bits 7:0. k=1 sets first-page bits 11:8 from data bits 3:0 and the 16-bit flag from bit 7. k=2 sets last-page bits 7:0. k=3 sets last-page bits 11:8 from bits 3:0 and the timing-set-1 flag from bit 6. k=4 sets offset bits 7:0. k=5 sets offset bits 13:8 from bits 5:0 and the attribute flag from bit 6. A write is sampled on a rising clock edge and affects translation from that edge on.
- R3: Bits 4:0 written at index 0x06 enable windows 0 to 4. A disabled window never produces a hit.
- R4: The page compare is inclusive at both ends: a host page hits when first <= page <= last.
- R5: On a hit, `card_addr` = {(host_addr[23:12] + offset) mod 2^14, host_addr[11:0]}, so the card address wraps.
- R6: On a hit, `attr_sel`, `wide16` and `tmr1_sel` carry the attribute, 16-bit and timing-set-1 flags of the winning window.
- R7: When several enabled windows match, the lowest-numbered one supplies the translation.
- R8: With bit 5 of index 0x06 set, the compare uses all twelve page bits. With it clear, page bits 4:0 of the host page and of both bounds are ignored in the compare, though the full page still feeds the sum.
- R9: Without a hit, all outputs other than the host-driven inputs read zero.
- R10: Writes to indices outside the enable register and the window registers, including bytes 6 and 7 of a window slot and slots of windows that do not exist, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 8 | Register write data |
| host_addr | input | 24 | Host memory address |
| hit | output | 1 | An enabled window covers the host address |
| card_addr | output | 26 | Translated card address |
| attr_sel | output | 1 | Access targets attribute memory |
| wide16 | output | 1 | Window uses a 16-bit data path |
| tmr1_sel | output | 1 | Window uses timing set 1 |

## Verification
Host addresses are tried just below, at and just above each window's first and last pages. This separates an inclusive compare from an exclusive one. Addresses in the overlap of two windows, repeated with the lower window disabled, show whether priority or the enable decides. An offset that pushes the page past 2^14 exposes a missing wrap. The same addresses are tried with coarse decode selected, which shows whether the low page bits are masked out of the compare while still feeding the sum.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  localparam int PAGE_W   = 12;
  localparam int OFF_W    = 14;
  localparam int PG_SHIFT = 12;
  localparam int HOST_W   = PAGE_W + PG_SHIFT;
  localparam int CARD_W   = OFF_W + PG_SHIFT;

  typedef struct packed {
    logic [PAGE_W-1:0] first;
    logic              wide;
    logic [PAGE_W-1:0] last;
    logic              tmr1;
    logic [OFF_W-1:0]  off;
    logic              attr;
  } win_cfg_t;
endpackage

// File: rtl/mwt_rst_sync.sv
module mwt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mwt_window.sv
module mwt_window
  import mwt_pkg::*;
#(
  parameter int COARSE_LSBS = 5
) (
  input  win_cfg_t          cfg,
  input  logic              en,
  input  logic              full_dec,
  input  logic [PAGE_W-1:0] host_page,
  output logic              match,
  output logic [OFF_W-1:0]  card_page
);
  localparam logic [PAGE_W-1:0] CMASK = ~PAGE_W'((1 << COARSE_LSBS) - 1);

  logic [PAGE_W-1:0] mask, hp_m, lo_m, hi_m;

  always_comb begin
    mask      = full_dec ? '1 : CMASK;
    hp_m      = host_page & mask;
    lo_m      = cfg.first & mask;
    hi_m      = cfg.last  & mask;
    match     = en && (hp_m >= lo_m) && (hp_m <= hi_m);
    card_page = OFF_W'(host_page) + cfg.off;
  end
endmodule

// File: rtl/mwt_pick.sv
module mwt_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb grant = req & (~req + N'(1));
endmodule

// File: rtl/mwt_translator.sv
module mwt_translator
  import mwt_pkg::*;
#(
  parameter int NWIN        = 5,
  parameter int ADDR_W      = 6,
  parameter int EN_INDEX    = 'h06,
  parameter int FULL_BIT    = 5,
  parameter int WIN_BASE    = 'h10,
  parameter int WIN_STRIDE  = 8,
  parameter int COARSE_LSBS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic [HOST_W-1:0] host_addr,
  output logic              hit,
  output logic [CARD_W-1:0] card_addr,
  output logic              attr_sel,
  output logic              wide16,
  output logic              tmr1_sel
);
  localparam int HI_W = PAGE_W - 8;
  localparam int OH_W = OFF_W - 8;

  logic rst_sync_n;

  mwt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  win_cfg_t        cfg_q [NWIN];
  win_cfg_t        cfg_d [NWIN];
  logic [NWIN-1:0] en_q, en_d;
  logic            full_q, full_d;

  // next state of the register file
  always_comb begin
    for (int n = 0; n < NWIN; n++) cfg_d[n] = cfg_q[n];
    en_d   = en_q;
    full_d = full_q;
    if (reg_we) begin
      if (reg_addr == ADDR_W'(EN_INDEX)) begin
        en_d   = reg_wdata[NWIN-1:0];
        full_d = reg_wdata[FULL_BIT];
      end
      for (int n = 0; n < NWIN; n++) begin
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 0))
          cfg_d[n].first[7:0] = reg_wdata;
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 1)) begin
          cfg_d[n].first[PAGE_W-1:8] = reg_wdata[HI_W-1:0];
          cfg_d[n].wide              = reg_wdata[7];
        end
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 2))
          cfg_d[n].last[7:0] = reg_wdata;
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 3)) begin
          cfg_d[n].last[PAGE_W-1:8] = reg_wdata[HI_W-1:0];
          cfg_d[n].tmr1             = reg_wdata[6];
        end
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 4))
          cfg_d[n].off[7:0] = reg_wdata;
        if (reg_addr == ADDR_W'(WIN_BASE + WIN_STRIDE*n + 5)) begin
          cfg_d[n].off[OFF_W-1:8] = reg_wdata[OH_W-1:0];
          cfg_d[n].attr           = reg_wdata[6];
        end
      end
    end
  end

  // register process, write strobe as clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int n = 0; n < NWIN; n++) cfg_q[n] <= '0;
      en_q   <= '0;
      full_q <= 1'b0;
    end else if (reg_we) begin
      for (int n = 0; n < NWIN; n++) cfg_q[n] <= cfg_d[n];
      en_q   <= en_d;
      full_q <= full_d;
    end
  end

  // per-window compare and sum
  logic [PAGE_W-1:0] host_page;
  logic [NWIN-1:0]   match;
  logic [OFF_W-1:0]  cpage [NWIN];
  logic [NWIN-1:0]   grant;

  assign host_page = host_addr[HOST_W-1:PG_SHIFT];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    mwt_window #(.COARSE_LSBS(COARSE_LSBS)) u_win (
      .cfg       (cfg_q[g]),
      .en        (en_q[g]),
      .full_dec  (full_q),
      .host_page (host_page),
      .match     (match[g]),
      .card_page (cpage[g])
    );
  end

  mwt_pick #(.N(NWIN)) u_pick (.req(match), .grant(grant));

  // one-hot AND-OR output select
  logic [OFF_W-1:0] sel_page;

  always_comb begin
    sel_page = '0;
    attr_sel = 1'b0;
    wide16   = 1'b0;
    tmr1_sel = 1'b0;
    for (int n = 0; n < NWIN; n++) begin
      sel_page = sel_page | (cpage[n] & {OFF_W{grant[n]}});
      attr_sel = attr_sel | (cfg_q[n].attr & grant[n]);
      wide16   = wide16   | (cfg_q[n].wide & grant[n]);
      tmr1_sel = tmr1_sel | (cfg_q[n].tmr1 & grant[n]);
    end
    hit       = |grant;
    card_addr = hit ? {sel_page, host_addr[PG_SHIFT-1:0]} : '0;
  end
endmodule

// File: rtl/mwt_checker.sv
module mwt_checker #(
  parameter int NWIN     = 5,
  parameter int ADDR_W   = 6,
  parameter int EN_INDEX = 'h06,
  parameter int HOST_W   = 24,
  parameter int CARD_W   = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [HOST_W-1:0] host_addr,
  input logic              hit,
  input logic [CARD_W-1:0] card_addr,
  input logic              attr_sel,
  input logic              wide16,
  input logic              tmr1_sel,
  input logic [NWIN-1:0]   en_q,
  input logic [NWIN-1:0]   grant
);
  a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (card_addr == '0 && !attr_sel && !wide16 && !tmr1_sel));

  a_r5_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> card_addr[11:0] == host_addr[11:0]);

  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r3_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !hit);

  a_r3_clear_write_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(EN_INDEX) && reg_wdata[NWIN-1:0] == '0) |=> !hit);
endmodule

bind mwt_translator mwt_checker #(
  .NWIN(NWIN), .ADDR_W(ADDR_W), .EN_INDEX(EN_INDEX),
  .HOST_W(mwt_pkg::HOST_W), .CARD_W(mwt_pkg::CARD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .host_addr(host_addr), .hit(hit),
  .card_addr(card_addr), .attr_sel(attr_sel), .wide16(wide16),
  .tmr1_sel(tmr1_sel), .en_q(en_q), .grant(grant)
);

// File: tb/sim_mwt_translator.sv
module sim_mwt_translator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [23:0] host_addr;
  logic        hit, attr_sel, wide16, tmr1_sel;
  logic [25:0] card_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mwt_translator u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .host_addr(host_addr), .hit(hit),
    .card_addr(card_addr), .attr_sel(attr_sel), .wide16(wide16),
    .tmr1_sel(tmr1_sel)
  );

  // {host, hit, card, attr, wide, tmr1}; windows: w0 0x010..0x01F off 0x0100 wide,
  // w1 0x018..0x020 off 0x3FF0 attr tmr1, w2 0xF00..0xFFF off 0x0200
  localparam logic [53:0] VEC [8] = '{
    {24'h00F123, 1'b0, 26'h0000000, 1'b0, 1'b0, 1'b0},  // R4 below first page
    {24'h010ABC, 1'b1, 26'h0110ABC, 1'b0, 1'b1, 1'b0},  // R4 at first page, R6 wide
    {24'h01F001, 1'b1, 26'h011F001, 1'b0, 1'b1, 1'b0},  // R7 overlap, last page of w0
    {24'h018555, 1'b1, 26'h0118555, 1'b0, 1'b1, 1'b0},  // R7 overlap, w0 wins
    {24'h020777, 1'b1, 26'h0010777, 1'b1, 1'b0, 1'b1},  // R5 wrap, R6 attr/tmr1
    {24'h021000, 1'b0, 26'h0000000, 1'b0, 1'b0, 1'b0},  // R4 above last page, R9
    {24'hF00000, 1'b1, 26'h1100000, 1'b0, 1'b0, 1'b0},  // R5 sum
    {24'hFFFFFF, 1'b1, 26'h11FFFFF, 1'b0, 1'b0, 1'b0}   // R4 top of space
  };

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [23:0] ha, input logic eh,
                     input logic [25:0] ec, input logic ea, input logic ew, input logic et);
    @(negedge clk);
    host_addr = ha;
    #1;
    checks++;
    if (hit !== eh || card_addr !== ec || attr_sel !== ea || wide16 !== ew || tmr1_sel !== et) begin
      fails++;
      $display("FAIL %s host=%h got hit=%b card=%h attr=%b wide=%b tmr=%b exp hit=%b card=%h attr=%b wide=%b tmr=%b",
               req, ha, hit, card_addr, attr_sel, wide16, tmr1_sel, eh, ec, ea, ew, et);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; host_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset", 24'h010ABC, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);

    // R2 program windows
    wr(6'h10, 8'h10); wr(6'h11, 8'h80); wr(6'h12, 8'h1F);
    wr(6'h13, 8'h00); wr(6'h14, 8'h00); wr(6'h15, 8'h01);
    wr(6'h18, 8'h18); wr(6'h19, 8'h00); wr(6'h1A, 8'h20);
    wr(6'h1B, 8'h40); wr(6'h1C, 8'hF0); wr(6'h1D, 8'h7F);
    wr(6'h20, 8'h00); wr(6'h21, 8'h0F); wr(6'h22, 8'hFF);
    wr(6'h23, 8'h0F); wr(6'h24, 8'h00); wr(6'h25, 8'h02);

    chk("R3 configured but disabled", 24'h010ABC, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);

    wr(6'h06, 8'h27);  // w0..w2, full decode
    for (int i = 0; i < 8; i++)
      chk("R2 R4 R5 R6 R7 vector", VEC[i][53:30], VEC[i][29], VEC[i][28:3],
          VEC[i][2], VEC[i][1], VEC[i][0]);

    // R3: drop w0, overlap falls to w1
    wr(6'h06, 8'h26);
    chk("R3 w0 disabled", 24'h010ABC, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);
    chk("R3 R7 w1 takes overlap", 24'h018555, 1'b1, 26'h0008555, 1'b1, 1'b0, 1'b1);

    // R8: w1 alone, coarse compare
    wr(6'h06, 8'h02);
    chk("R8 coarse hit below first", 24'h005123, 1'b1, 26'h3FF5123, 1'b1, 1'b0, 1'b1);
    chk("R8 coarse hit above last", 24'h03F010, 1'b1, 26'h002F010, 1'b1, 1'b0, 1'b1);
    chk("R8 coarse miss", 24'h040000, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);

    // R10: unmapped writes
    wr(6'h06, 8'h27);
    wr(6'h05, 8'hFF); wr(6'h07, 8'hFF); wr(6'h16, 8'hFF); wr(6'h17, 8'hFF);
    wr(6'h1E, 8'hFF); wr(6'h1F, 8'hFF);
    wr(6'h38, 8'h00); wr(6'h39, 8'h00); wr(6'h3A, 8'hFF); wr(6'h3B, 8'h0F);
    wr(6'h3C, 8'h55); wr(6'h3D, 8'h7F);
    chk("R10 w0 unchanged", 24'h010ABC, 1'b1, 26'h0110ABC, 1'b0, 1'b1, 1'b0);
    chk("R10 no phantom window", 24'h021000, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);
    chk("R10 w1 unchanged", 24'h020777, 1'b1, 26'h0010777, 1'b1, 1'b0, 1'b1);

    // R1 again after a second reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset clears windows", 24'hF00000, 1'b0, 26'h0, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule